// File: doc/BRIEF.md
# Register Rename Map with Undo History

This block is the register-renaming core of an out-of-order pipeline. A map table records which physical register currently holds each architectural register. A free-list FIFO supplies unused physical registers. Each rename takes one instruction with a sequence number, an optional destination and two source architectural registers. In the same cycle it returns the physical registers of the two sources, the physical register newly allocated to the destination, and the mapping that the destination had before the rename.

Every accepted rename pushes one entry onto a circular history queue at its young end. The entry records the sequence number, the architectural destination, the new and previous physical registers, and a placeholder flag for instructions that have no destination. Two kinds of request walk this queue, one entry per cycle, while `busy_o` is high. A squash request keeps sequence numbers up to a surviving number S. It pops entries from the young end while their sequence number is above S, rolls the map back, and returns each new register to the free list. A commit request retires sequence numbers up to a number C. It pops entries from the old end while their sequence number is at most C, and returns each previous register to the free list.

Sequence numbers are compared as unsigned values and are expected to increase from old to young without wrapping.

Top module: `rename_hist_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list hands out physical registers NUM_ARCH, NUM_ARCH+1, … NUM_PHYS-1 in that order. The history queue is empty, `busy_o` is 0 and `lookup_cnt_o` is 0.
- R2: An accepted rename with a destination returns the free-list head as `ren_new_o` and the destination's current mapping as `ren_prev_o`, both in the same cycle. It then maps the destination to `ren_new_o`.
- R3: `ren_src0_o`/`ren_src1_o` show the current map entry of each source in the same cycle. A source equal to the instruction's own destination gets the mapping from before this rename.
- R4: A rename without a destination (`ren_has_dst_i`=0) is accepted even when the free list is empty. It takes one history slot, leaves the map unchanged and consumes no physical register.
- R5: `ren_nofree_o` is 1 when the history queue is full, or when `ren_has_dst_i`=1 and the free list is empty. A rename is then refused (`ren_ok_o`=0) and no state changes.
- R6: A squash with surviving number S removes history entries from the young end while their sequence number is greater than S. For each entry that is not a placeholder, the destination's mapping is restored to the previous register and the new register is appended to the free list, youngest first. Placeholders free nothing.
- R7: A commit of number C removes history entries from the old end while their sequence number is at most C. For each entry that is not a placeholder, the previous register is appended to the free list, oldest first.
- R8: When `sq_valid_i` and `cmt_valid_i` are high in the same cycle, only the squash is performed and the commit is dropped.
- R9: `busy_o` rises on the clock edge that accepts a commit or squash. It stays high for one cycle per removed entry plus one final cycle. No rename is accepted while `busy_o` is high or while a commit or squash request is presented.
- R10: `lookup_cnt_o` increases by 2 (two source lookups) on each accepted rename and holds otherwise.
- R11: A squash that arrives while a commit walk is running takes over at once. The commit removes nothing more, including in the cycle the squash arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request |
| ren_seq_i | input | SEQ_W | Sequence number of the renamed instruction |
| ren_has_dst_i | input | 1 | Instruction writes a destination |
| ren_dst_i | input | log2(NUM_ARCH) | Architectural destination |
| ren_src0_i | input | log2(NUM_ARCH) | Architectural source 0 |
| ren_src1_i | input | log2(NUM_ARCH) | Architectural source 1 |
| ren_ok_o | output | 1 | Rename accepted this cycle |
| ren_nofree_o | output | 1 | No free register or history slot |
| ren_src0_o | output | log2(NUM_PHYS) | Physical register of source 0 |
| ren_src1_o | output | log2(NUM_PHYS) | Physical register of source 1 |
| ren_new_o | output | log2(NUM_PHYS) | Newly allocated physical register |
| ren_prev_o | output | log2(NUM_PHYS) | Previous mapping of the destination |
| cmt_valid_i | input | 1 | Commit request |
| cmt_seq_i | input | SEQ_W | Youngest completed sequence number |
| sq_valid_i | input | 1 | Squash request |
| sq_seq_i | input | SEQ_W | Youngest surviving sequence number |
| busy_o | output | 1 | History walk in progress |
| lookup_cnt_o | output | CNT_W | Running count of source lookups |

## Verification
Commit and squash can be requested in the same cycle. The bench drives both on one edge, with a commit number that covers the entry the squash removes. A correct design removes that entry through the squash path: the destination's mapping rolls back, so the next rename of it reports the older register as previous. A committed entry would report the rolled-forward one instead. A second case issues a squash on the cycle right after a commit is accepted. The order in which later renames draw registers from the free list then shows that the commit freed nothing.

// File: rtl/rhu_pkg.sv
package rhu_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_SQ   = 2'd1,
    WALK_CM   = 2'd2
  } walk_e;
endpackage

// File: rtl/rhu_map_table.sv
module rhu_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [PW-1:0] wd_i,
  input  logic [AW-1:0] ra0_i,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [PW-1:0] rd0_o,
  output logic [PW-1:0] rd1_o,
  output logic [PW-1:0] rd2_o
);
  logic [PW-1:0] map_q [NUM_ARCH];

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       map_q[i] <= PW'(i);
      else if (we_i && wa_i == AW'(i))   map_q[i] <= wd_i;
    end
  end

  assign rd0_o = map_q[ra0_i];
  assign rd1_o = map_q[ra1_i];
  assign rd2_o = map_q[ra2_i];
endmodule

// File: rtl/rhu_free_list.sv
module rhu_free_list #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int INIT_CNT = NUM_PHYS - NUM_ARCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [PW-1:0] push_d_i,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic          empty_o
);
  logic [PW-1:0] mem_q [NUM_PHYS];
  logic [PW-1:0] rd_q, wr_q;
  logic [PW:0]   cnt_q;

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mem_q[i] <= (i < INIT_CNT) ? PW'(NUM_ARCH + i) : '0;
      else if (push_i && wr_q == PW'(i))  mem_q[i] <= push_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= PW'(INIT_CNT);
      cnt_q <= (PW+1)'(INIT_CNT);
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop_i)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/rhu_history.sv
module rhu_history #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 8,
  parameter int AW    = 3,
  parameter int PW    = 4,
  localparam int HW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  input  logic [AW-1:0]    push_dst_i,
  input  logic [PW-1:0]    push_new_i,
  input  logic [PW-1:0]    push_prev_i,
  input  logic             push_ph_i,
  input  logic             pop_old_i,
  input  logic             pop_young_i,
  output logic [SEQ_W-1:0] old_seq_o,
  output logic [PW-1:0]    old_prev_o,
  output logic             old_ph_o,
  output logic [SEQ_W-1:0] yng_seq_o,
  output logic [AW-1:0]    yng_dst_o,
  output logic [PW-1:0]    yng_new_o,
  output logic [PW-1:0]    yng_prev_o,
  output logic             yng_ph_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [SEQ_W-1:0] seq_m  [DEPTH];
  logic [AW-1:0]    dst_m  [DEPTH];
  logic [PW-1:0]    new_m  [DEPTH];
  logic [PW-1:0]    prev_m [DEPTH];
  logic             ph_m   [DEPTH];
  logic [HW:0]      hd_q, tl_q;
  logic [HW-1:0]    hi, ti, yi;

  assign hi = hd_q[HW-1:0];
  assign ti = tl_q[HW-1:0];
  assign yi = ti - 1'b1;

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      seq_m[ti]  <= push_seq_i;
      dst_m[ti]  <= push_dst_i;
      new_m[ti]  <= push_new_i;
      prev_m[ti] <= push_prev_i;
      ph_m[ti]   <= push_ph_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_q <= '0;
      tl_q <= '0;
    end else begin
      if (pop_old_i)        hd_q <= hd_q + 1'b1;
      if (push_i)           tl_q <= tl_q + 1'b1;
      else if (pop_young_i) tl_q <= tl_q - 1'b1;
    end
  end

  assign old_seq_o  = seq_m[hi];
  assign old_prev_o = prev_m[hi];
  assign old_ph_o   = ph_m[hi];
  assign yng_seq_o  = seq_m[yi];
  assign yng_dst_o  = dst_m[yi];
  assign yng_new_o  = new_m[yi];
  assign yng_prev_o = prev_m[yi];
  assign yng_ph_o   = ph_m[yi];
  assign empty_o    = (hd_q == tl_q);
  assign full_o     = (hd_q[HW-1:0] == tl_q[HW-1:0]) && (hd_q[HW] != tl_q[HW]);
endmodule

// File: rtl/rename_hist_unit.sv
module rename_hist_unit
  import rhu_pkg::*;
#(
  parameter int NUM_ARCH   = 8,
  parameter int NUM_PHYS   = 16,
  parameter int HIST_DEPTH = 16,
  parameter int SEQ_W      = 8,
  parameter int CNT_W      = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren_valid_i,
  input  logic [SEQ_W-1:0] ren_seq_i,
  input  logic             ren_has_dst_i,
  input  logic [AW-1:0]    ren_dst_i,
  input  logic [AW-1:0]    ren_src0_i,
  input  logic [AW-1:0]    ren_src1_i,
  output logic             ren_ok_o,
  output logic             ren_nofree_o,
  output logic [PW-1:0]    ren_src0_o,
  output logic [PW-1:0]    ren_src1_o,
  output logic [PW-1:0]    ren_new_o,
  output logic [PW-1:0]    ren_prev_o,
  input  logic             cmt_valid_i,
  input  logic [SEQ_W-1:0] cmt_seq_i,
  input  logic             sq_valid_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] lookup_cnt_o
);
  walk_e            state_q;
  logic [SEQ_W-1:0] tgt_q;
  logic             walk_sq;

  logic             free_empty, hist_full, hist_empty;
  logic [PW-1:0]    free_head;
  logic [SEQ_W-1:0] o_seq, y_seq;
  logic [PW-1:0]    o_prev, y_new, y_prev;
  logic [AW-1:0]    y_dst;
  logic             o_ph, y_ph;

  logic             step_sq, step_cm, alloc;
  logic             map_we, fl_push;
  logic [AW-1:0]    map_wa;
  logic [PW-1:0]    map_wd, fl_d;

  assign busy_o  = (state_q != WALK_IDLE);
  assign walk_sq = (state_q == WALK_SQ);

  // refusal reasons are independent of the valid strobe
  assign ren_nofree_o = hist_full | (ren_has_dst_i & free_empty);
  assign ren_ok_o     = ren_valid_i & ~busy_o & ~sq_valid_i & ~cmt_valid_i & ~ren_nofree_o;
  assign alloc        = ren_ok_o & ren_has_dst_i;
  assign ren_new_o    = free_head;

  // a new squash request freezes any walk for one cycle while it is latched
  assign step_sq = walk_sq && !sq_valid_i && !hist_empty && (y_seq > tgt_q);
  assign step_cm = (state_q == WALK_CM) && !sq_valid_i && !hist_empty && (o_seq <= tgt_q);

  always_comb begin
    map_we  = 1'b0;
    map_wa  = ren_dst_i;
    map_wd  = free_head;
    fl_push = 1'b0;
    fl_d    = y_new;
    if (alloc) begin
      map_we = 1'b1;
    end else if (step_sq && !y_ph) begin
      map_we  = 1'b1;
      map_wa  = y_dst;
      map_wd  = y_prev;
      fl_push = 1'b1;
    end else if (step_cm && !o_ph) begin
      fl_push = 1'b1;
      fl_d    = o_prev;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      tgt_q   <= '0;
    end else if (sq_valid_i) begin
      state_q <= WALK_SQ;
      tgt_q   <= sq_seq_i;
    end else if (cmt_valid_i && !busy_o) begin
      state_q <= WALK_CM;
      tgt_q   <= cmt_seq_i;
    end else if ((walk_sq && !step_sq) || (state_q == WALK_CM && !step_cm)) begin
      state_q <= WALK_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lookup_cnt_o <= '0;
    else if (ren_ok_o) lookup_cnt_o <= lookup_cnt_o + CNT_W'(2);
  end

  rhu_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (map_we),
    .wa_i  (map_wa),
    .wd_i  (map_wd),
    .ra0_i (ren_src0_i),
    .ra1_i (ren_src1_i),
    .ra2_i (ren_dst_i),
    .rd0_o (ren_src0_o),
    .rd1_o (ren_src1_o),
    .rd2_o (ren_prev_o)
  );

  rhu_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fl_push),
    .push_d_i(fl_d),
    .pop_i   (alloc),
    .head_o  (free_head),
    .empty_o (free_empty)
  );

  rhu_history #(.DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .AW(AW), .PW(PW)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ren_ok_o),
    .push_seq_i (ren_seq_i),
    .push_dst_i (ren_dst_i),
    .push_new_i (free_head),
    .push_prev_i(ren_prev_o),
    .push_ph_i  (~ren_has_dst_i),
    .pop_old_i  (step_cm),
    .pop_young_i(step_sq),
    .old_seq_o  (o_seq),
    .old_prev_o (o_prev),
    .old_ph_o   (o_ph),
    .yng_seq_o  (y_seq),
    .yng_dst_o  (y_dst),
    .yng_new_o  (y_new),
    .yng_prev_o (y_prev),
    .yng_ph_o   (y_ph),
    .empty_o    (hist_empty),
    .full_o     (hist_full)
  );
endmodule

// File: rtl/rename_hist_unit_chk.sv
module rename_hist_unit_chk #(
  parameter int PW    = 4,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ren_ok_i,
  input logic             ren_has_dst_i,
  input logic [PW-1:0]    ren_new_i,
  input logic [PW-1:0]    ren_prev_i,
  input logic             busy_i,
  input logic             sq_valid_i,
  input logic             cmt_valid_i,
  input logic             walk_sq_i,
  input logic             hist_full_i,
  input logic             free_empty_i,
  input logic [CNT_W-1:0] lookup_cnt_i
);
  assert_fresh_dst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_ok_i && ren_has_dst_i |-> ren_new_i != ren_prev_i);

  assert_full_refuse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_full_i || (ren_has_dst_i && free_empty_i)) |-> !ren_ok_i);

  assert_sq_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_valid_i && cmt_valid_i) |=> walk_sq_i);

  assert_no_ren_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_ok_i |-> !busy_i);

  assert_req_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_valid_i |=> busy_i);

  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_ok_i |=> lookup_cnt_i == CNT_W'($past(lookup_cnt_i) + CNT_W'(2)));

  assert_cnt_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_ok_i |=> $stable(lookup_cnt_i));
endmodule

bind rename_hist_unit rename_hist_unit_chk #(.PW(PW), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ren_ok_i     (ren_ok_o),
  .ren_has_dst_i(ren_has_dst_i),
  .ren_new_i    (ren_new_o),
  .ren_prev_i   (ren_prev_o),
  .busy_i       (busy_o),
  .sq_valid_i   (sq_valid_i),
  .cmt_valid_i  (cmt_valid_i),
  .walk_sq_i    (walk_sq),
  .hist_full_i  (hist_full),
  .free_empty_i (free_empty),
  .lookup_cnt_i (lookup_cnt_o)
);

// File: tb/rename_hist_unit_bench.sv
module rename_hist_unit_bench;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ren_valid_i = 1'b0, ren_has_dst_i = 1'b0;
  logic [7:0] ren_seq_i = '0, cmt_seq_i = '0, sq_seq_i = '0;
  logic [2:0] ren_dst_i = '0, ren_src0_i = '0, ren_src1_i = '0;
  logic       cmt_valid_i = 1'b0, sq_valid_i = 1'b0;
  logic       ren_ok_o, ren_nofree_o, busy_o;
  logic [3:0] ren_src0_o, ren_src1_o, ren_new_o, ren_prev_o;
  logic [15:0] lookup_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rename_hist_unit u_rename_hist_unit (.*);

  typedef struct packed {
    logic [7:0] seq;
    logic       hd;
    logic [2:0] dst, s0, s1;
    logic [3:0] nw, pv, p0, p1;
    logic [3:0] req;
  } vec_t;

  // R2 / R4 / R3 vectors from reset state
  localparam vec_t VEC [4] = '{
    '{8'd1, 1'b1, 3'd1, 3'd1, 3'd2, 4'd8,  4'd1, 4'd1, 4'd2, 4'd2},
    '{8'd2, 1'b1, 3'd2, 3'd1, 3'd2, 4'd9,  4'd2, 4'd8, 4'd2, 4'd2},
    '{8'd3, 1'b0, 3'd0, 3'd1, 3'd2, 4'd0,  4'd0, 4'd8, 4'd9, 4'd4},
    '{8'd4, 1'b1, 3'd1, 3'd3, 3'd1, 4'd10, 4'd8, 4'd3, 4'd8, 4'd3}
  };

  localparam logic [3:0] FILL_NEW [8] = '{4'd13, 4'd14, 4'd15, 4'd10, 4'd1, 4'd2, 4'd11, 4'd8};
  localparam logic [3:0] FILL_PRV [8] = '{4'd3, 4'd13, 4'd14, 4'd15, 4'd10, 4'd1, 4'd2, 4'd11};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ren(input int seq, input bit hd, input int dst, input int s0, input int s1,
                     input bit eok, input int enew, input int epv, input int ep0, input int ep1,
                     input string req);
    @(negedge clk_i);
    ren_valid_i = 1'b1; ren_seq_i = 8'(seq); ren_has_dst_i = hd;
    ren_dst_i = 3'(dst); ren_src0_i = 3'(s0); ren_src1_i = 3'(s1);
    #1;
    chk({req, " ok"}, int'(ren_ok_o), int'(eok));
    if (eok && hd) begin
      chk({req, " new"}, int'(ren_new_o), enew);
      chk({req, " prev"}, int'(ren_prev_o), epv);
    end
    if (!eok) chk({req, " nofree"}, int'(ren_nofree_o), 1);
    chk({req, " src0"}, int'(ren_src0_o), ep0);
    chk({req, " src1"}, int'(ren_src1_o), ep1);
    if (eok) exp_cnt += 2;
    @(posedge clk_i); #1;
    ren_valid_i = 1'b0;
  endtask

  // issue walk request(s); count busy cycles
  task automatic walk(input bit c, input int cs, input bit s, input int ss,
                      input int ebusy, input string req);
    int n = 0;
    @(negedge clk_i);
    cmt_valid_i = c; cmt_seq_i = 8'(cs); sq_valid_i = s; sq_seq_i = 8'(ss);
    @(posedge clk_i); #1;
    cmt_valid_i = 1'b0; sq_valid_i = 1'b0;
    while (busy_o && n < 100) begin
      n++;
      @(posedge clk_i); #1;
    end
    chk({req, " busy cycles"}, n, ebusy);
  endtask

  initial begin
    #(CLK_P*50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    ren_src0_i = 3'd5; ren_src1_i = 3'd7;
    #1;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 cnt", int'(lookup_cnt_o), 0);
    chk("R1 src0", int'(ren_src0_o), 5);
    chk("R1 src1", int'(ren_src1_o), 7);
    chk("R1 nofree", int'(ren_nofree_o), 0);

    for (int i = 0; i < 4; i++)
      ren(VEC[i].seq, VEC[i].hd, VEC[i].dst, VEC[i].s0, VEC[i].s1, 1'b1,
          VEC[i].nw, VEC[i].pv, VEC[i].p0, VEC[i].p1, $sformatf("R%0d vec%0d", VEC[i].req, i));

    // R6 squash S=2: pops seq4 and placeholder seq3
    walk(1'b0, 0, 1'b1, 2, 3, "R6/R9 squash");
    ren(3, 1'b1, 1, 1, 2, 1'b1, 11, 8, 8, 9, "R6 restored map");
    // R7 commit C=2 frees prev 1 and 2
    walk(1'b1, 2, 1'b0, 0, 3, "R7 commit");
    // R8 commit C=3 with squash S=2: squash only
    walk(1'b1, 3, 1'b1, 2, 2, "R8 same cycle");
    ren(3, 1'b1, 1, 1, 1, 1'b1, 12, 8, 8, 8, "R8 commit dropped");
    walk(1'b1, 3, 1'b0, 0, 2, "R7 commit frees 8");

    // R7 free-list order after commits; R2 allocation order
    for (int i = 0; i < 8; i++)
      ren(10 + i, 1'b1, 3, 3, 0, 1'b1, FILL_NEW[i], FILL_PRV[i], FILL_PRV[i], 0, "R7 fill order");
    ren(18, 1'b1, 3, 0, 0, 1'b0, 0, 0, 0, 0, "R5 free empty");
    for (int i = 0; i < 8; i++)
      ren(18 + i, 1'b0, 0, 0, 0, 1'b1, 0, 0, 0, 0, "R4 placeholder");
    ren(26, 1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 0, "R5 history full");
    walk(1'b0, 0, 1'b1, 17, 9, "R6 placeholder squash");
    ren(18, 1'b1, 3, 0, 0, 1'b0, 0, 0, 0, 0, "R6 placeholders free nothing");
    walk(1'b0, 0, 1'b1, 15, 3, "R6 squash two");
    ren(16, 1'b1, 3, 3, 0, 1'b1, 8, 2, 2, 0, "R6 youngest freed first");

    // R11 commit C=15 then squash S=14 on the next cycle
    @(negedge clk_i);
    cmt_valid_i = 1'b1; cmt_seq_i = 8'd15;
    @(posedge clk_i); #1;
    cmt_valid_i = 1'b0;
    sq_valid_i = 1'b1; sq_seq_i = 8'd14;
    chk("R9 busy after commit", int'(busy_o), 1);
    @(posedge clk_i); #1;
    sq_valid_i = 1'b0;
    for (int n = 0; n < 100 && busy_o; n++) begin
      @(posedge clk_i); #1;
    end
    chk("R11 walk ended", int'(busy_o), 0);
    ren(15, 1'b1, 3, 3, 0, 1'b1, 11, 1, 1, 0, "R11 squash took over");
    ren(16, 1'b1, 4, 4, 0, 1'b1, 8, 4, 4, 0, "R11 commit freed nothing");

    #1;
    chk("R10 lookup count", int'(lookup_cnt_o), exp_cnt);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule